// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This block turns the addressing byte that follows an opcode into a 16-bit effective offset for a real-mode x86-style core. The core hands over the addressing byte together with the current BX, BP, SI and DI values, the code segment and the instruction pointer that points just past the addressing byte. The block decides from the mode field how many displacement bytes belong to the operand, pulls them from the instruction stream one at a time through a simple request/valid port, and then presents the offset, the segment hint and the decoded fields for one cycle.

The block also reports whether the operand is a register rather than memory, and which segment the offset defaults to: stack-based forms default to SS, all others to DS. It returns the instruction pointer advanced past the consumed displacement, so the core can continue fetching from there. Register-file reads, segment overrides and the data access itself are left to the surrounding logic.

Top module: `ea_modrm_gen`

## Requirements
- R1: The addressing byte is split as mode = bits 7:6, reg = bits 5:3, rm = bits 2:0; `reg_o` and `rm_o` carry the reg and rm fields of the accepted byte.
- R2: For mode 00 with rm other than 110 no displacement is fetched, and the offset is the base chosen by rm: 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX.
- R3: Mode 00 with rm 110 uses no base register: two bytes are fetched, low byte first, and that 16-bit value is the offset.
- R4: Mode 01 fetches one byte, sign-extends it to 16 bits and adds it to the rm base.
- R5: Mode 10 fetches two bytes, low byte first, and adds the 16-bit value to the rm base.
- R6: `ss_dflt_o` is 1 exactly when the memory base contains BP (rm 2 or 3 in modes 00, 01, 10; rm 6 in modes 01 and 10); it is 0 for the direct-address form and for mode 11.
- R7: Each displacement byte is requested at physical address ((CS << 4) + IP) truncated to 20 bits, IP advancing by one (modulo 2^16) after each byte; `ip_o` returns the advanced IP.
- R8: Mode 11 fetches nothing and reports `reg_direct_o` = 1 with `ea_o` = 0 and `ss_dflt_o` = 0.
- R9: The offset sum wraps modulo 2^16.
- R10: A byte is taken only in a cycle where `fetch_req_o` and `fetch_valid_i` are both high; while `fetch_valid_i` is low the request and its address hold.
- R11: `start_i` is ignored while `busy_o` is high; the result in flight and the number of completions are unaffected.
- R12: After reset `busy_o`, `done_o` and `fetch_req_o` are 0.
- R13: `done_o` is a one-cycle pulse that rises the cycle after the last displacement byte is taken, or the cycle after acceptance when no byte is needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Addressing byte and register values are valid |
| modrm_i | input | 8 | Addressing byte |
| bx_i | input | 16 | BX value |
| bp_i | input | 16 | BP value |
| si_i | input | 16 | SI value |
| di_i | input | 16 | DI value |
| cs_i | input | 16 | Code segment |
| ip_i | input | 16 | IP of the first byte after the addressing byte |
| fetch_req_o | output | 1 | Displacement byte wanted |
| fetch_addr_o | output | 20 | Physical address of the wanted byte |
| fetch_valid_i | input | 1 | `fetch_data_i` holds the requested byte |
| fetch_data_i | input | 8 | Displacement byte |
| busy_o | output | 1 | Operation in progress; new starts ignored |
| done_o | output | 1 | Result valid this cycle |
| ea_o | output | 16 | Effective offset |
| ss_dflt_o | output | 1 | Default segment is SS |
| reg_o | output | 3 | reg field |
| reg_direct_o | output | 1 | Operand is the register indexed by rm |
| rm_o | output | 3 | rm field |
| ip_o | output | 16 | IP after the displacement |

## Verification
A wrong byte count shows up at `ip_o` and at the `done_o` latency in the same result, while a wrong fetch address changes the displacement bytes the memory model returns and so corrupts `ea_o` at that same pulse. A wrong base selection or sign extension is visible in `ea_o` at the first completion using the affected rm and mode, and a mistaken SS hint appears on `ss_dflt_o` together with it. A state machine that accepts a start while busy shows as an extra `done_o` pulse or a result built from the wrong addressing byte within a few cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_FETCH, ST_DONE} ea_state_e;

  localparam logic [1:0] MOD_NODISP = 2'b00;
  localparam logic [1:0] MOD_DISP8  = 2'b01;
  localparam logic [1:0] MOD_DISP16 = 2'b10;
  localparam logic [1:0] MOD_REG    = 2'b11;
  localparam logic [2:0] RM_DIRECT  = 3'b110;

  // number of displacement bytes implied by an addressing byte
  function automatic logic [1:0] disp_len(input logic [7:0] mb);
    case (mb[7:6])
      MOD_NODISP: disp_len = (mb[2:0] == RM_DIRECT) ? 2'd2 : 2'd0;
      MOD_DISP8:  disp_len = 2'd1;
      MOD_DISP16: disp_len = 2'd2;
      default:    disp_len = 2'd0;
    endcase
  endfunction
endpackage

// File: rtl/ea_disp_fetch.sv
module ea_disp_fetch #(
  parameter int OFS_W     = 16,
  parameter int PHYS_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [OFS_W-1:0]  cs_i,
  input  logic [OFS_W-1:0]  ip_i,
  input  logic [1:0]        need_i,
  input  logic              active_i,
  input  logic              valid_i,
  input  logic [7:0]        data_i,
  output logic              req_o,
  output logic [PHYS_W-1:0] addr_o,
  output logic [OFS_W-1:0]  disp_o,
  output logic [OFS_W-1:0]  ip_o,
  output logic              last_o
);
  localparam int SUM_W = OFS_W + SEG_SHIFT + 1;

  logic [OFS_W-1:0] cs_q, ip_q;
  logic [1:0]       cnt_q;
  logic [7:0]       lo_q, hi_q;
  logic [SUM_W-1:0] phys_sum;
  logic             take;

  assign req_o    = active_i;
  assign take     = req_o & valid_i;
  assign phys_sum = SUM_W'({cs_q, {SEG_SHIFT{1'b0}}}) + SUM_W'(ip_q);
  assign addr_o   = phys_sum[PHYS_W-1:0];
  assign disp_o   = OFS_W'({hi_q, lo_q});
  assign ip_o     = ip_q;
  assign last_o   = take & ((cnt_q + 2'd1) == need_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_q  <= '0;
      ip_q  <= '0;
      cnt_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (load_i) begin
      cs_q  <= cs_i;
      ip_q  <= ip_i;
      cnt_q <= '0;
      lo_q  <= '0;
      hi_q  <= '0;
    end else if (take) begin
      if (cnt_q == 2'd0) lo_q <= data_i;
      else               hi_q <= data_i;
      ip_q  <= ip_q + 1'b1;
      cnt_q <= cnt_q + 2'd1;
    end
  end

  p_hold_addr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !valid_i) |=> (req_o && $stable(addr_o)));

  p_ip_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take && !load_i) |=> (ip_o == $past(ip_o) + 1'b1));
endmodule

// File: rtl/ea_calc.sv
module ea_calc
  import ea_pkg::*;
#(
  parameter int OFS_W = 16
) (
  input  logic [7:0]       modrm_i,
  input  logic [OFS_W-1:0] bx_i,
  input  logic [OFS_W-1:0] bp_i,
  input  logic [OFS_W-1:0] si_i,
  input  logic [OFS_W-1:0] di_i,
  input  logic [OFS_W-1:0] disp_i,
  output logic [OFS_W-1:0] ea_o,
  output logic             ss_o,
  output logic             direct_reg_o
);
  logic [1:0]       md;
  logic [2:0]       rm;
  logic             abs_addr;
  logic [OFS_W-1:0] base, disp_ext;

  assign md       = modrm_i[7:6];
  assign rm       = modrm_i[2:0];
  assign abs_addr = (md == MOD_NODISP) && (rm == RM_DIRECT);

  always_comb begin
    case (rm)
      3'd0:    base = bx_i + si_i;
      3'd1:    base = bx_i + di_i;
      3'd2:    base = bp_i + si_i;
      3'd3:    base = bp_i + di_i;
      3'd4:    base = si_i;
      3'd5:    base = di_i;
      3'd6:    base = abs_addr ? '0 : bp_i;
      default: base = bx_i;
    endcase
  end

  always_comb begin
    case (md)
      MOD_NODISP: disp_ext = abs_addr ? disp_i : '0;
      MOD_DISP8:  disp_ext = {{(OFS_W-8){disp_i[7]}}, disp_i[7:0]};
      MOD_DISP16: disp_ext = disp_i;
      default:    disp_ext = '0;
    endcase
  end

  assign direct_reg_o = (md == MOD_REG);
  assign ea_o         = direct_reg_o ? '0 : base + disp_ext;
  assign ss_o         = !direct_reg_o &&
                        ((rm == 3'd2) || (rm == 3'd3) || ((rm == RM_DIRECT) && !abs_addr));
endmodule

// File: rtl/ea_modrm_gen.sv
module ea_modrm_gen
  import ea_pkg::*;
#(
  parameter int OFS_W     = 16,
  parameter int PHYS_W    = 20,
  parameter int SEG_SHIFT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [7:0]        modrm_i,
  input  logic [OFS_W-1:0]  bx_i,
  input  logic [OFS_W-1:0]  bp_i,
  input  logic [OFS_W-1:0]  si_i,
  input  logic [OFS_W-1:0]  di_i,
  input  logic [OFS_W-1:0]  cs_i,
  input  logic [OFS_W-1:0]  ip_i,
  output logic              fetch_req_o,
  output logic [PHYS_W-1:0] fetch_addr_o,
  input  logic              fetch_valid_i,
  input  logic [7:0]        fetch_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [OFS_W-1:0]  ea_o,
  output logic              ss_dflt_o,
  output logic [2:0]        reg_o,
  output logic              reg_direct_o,
  output logic [2:0]        rm_o,
  output logic [OFS_W-1:0]  ip_o
);
  ea_state_e        state_q, state_d;
  logic [7:0]       modrm_q;
  logic [OFS_W-1:0] bx_q, bp_q, si_q, di_q, disp;
  logic [1:0]       need_q;
  logic             accept, last;

  assign accept = (state_q == ST_IDLE) && start_i;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start_i) state_d = (disp_len(modrm_i) == 2'd0) ? ST_DONE : ST_FETCH;
      ST_FETCH: if (last) state_d = ST_DONE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      modrm_q <= '0;
      need_q  <= '0;
      bx_q    <= '0;
      bp_q    <= '0;
      si_q    <= '0;
      di_q    <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        modrm_q <= modrm_i;
        need_q  <= disp_len(modrm_i);
        bx_q    <= bx_i;
        bp_q    <= bp_i;
        si_q    <= si_i;
        di_q    <= di_i;
      end
    end
  end

  ea_disp_fetch #(.OFS_W(OFS_W), .PHYS_W(PHYS_W), .SEG_SHIFT(SEG_SHIFT)) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (accept),
    .cs_i     (cs_i),
    .ip_i     (ip_i),
    .need_i   (need_q),
    .active_i (state_q == ST_FETCH),
    .valid_i  (fetch_valid_i),
    .data_i   (fetch_data_i),
    .req_o    (fetch_req_o),
    .addr_o   (fetch_addr_o),
    .disp_o   (disp),
    .ip_o     (ip_o),
    .last_o   (last)
  );

  ea_calc #(.OFS_W(OFS_W)) u_calc (
    .modrm_i      (modrm_q),
    .bx_i         (bx_q),
    .bp_i         (bp_q),
    .si_i         (si_q),
    .di_i         (di_q),
    .disp_i       (disp),
    .ea_o         (ea_o),
    .ss_o         (ss_dflt_o),
    .direct_reg_o (reg_direct_o)
  );

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = (state_q == ST_DONE);
  assign reg_o  = modrm_q[5:3];
  assign rm_o   = modrm_q[2:0];

  p_reg_no_fetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && modrm_i[7:6] == MOD_REG) |=> (done_o && reg_direct_o && !fetch_req_o));

  p_done_pulse_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_no_req_at_done_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !fetch_req_o);

  p_busy_holds_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(modrm_q));

  p_ss_mem_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && ss_dflt_o) |-> !reg_direct_o);
endmodule

// File: tb/ea_modrm_gen_bench.sv
module ea_modrm_gen_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [15:0] ea;
    logic        ss;
    logic [2:0]  rg;
    logic        dir;
    logic [2:0]  rm;
    logic [15:0] ip;
    string       tag;
  } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, fvalid = 1'b0;
  logic [7:0]  modrm = '0, fdata = '0;
  logic [15:0] bx = '0, bp = '0, si = '0, di = '0, cs = '0, ip = '0;
  logic        freq, busy, done, ss, rdir;
  logic [19:0] faddr;
  logic [15:0] ea, ip_out;
  logic [2:0]  rg, rm;

  int n_chk = 0, n_fail = 0;
  bit stall_mode = 1'b0, stall_ph = 1'b0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ea_modrm_gen u_ea_modrm_gen (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .modrm_i(modrm),
    .bx_i(bx), .bp_i(bp), .si_i(si), .di_i(di), .cs_i(cs), .ip_i(ip),
    .fetch_req_o(freq), .fetch_addr_o(faddr), .fetch_valid_i(fvalid),
    .fetch_data_i(fdata), .busy_o(busy), .done_o(done), .ea_o(ea),
    .ss_dflt_o(ss), .reg_o(rg), .reg_direct_o(rdir), .rm_o(rm), .ip_o(ip_out)
  );

  function automatic logic [7:0] mem_byte(input logic [19:0] a);
    return a[7:0] ^ a[19:12] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // memory model: answers requests, optionally every other cycle (R10)
  always @(negedge clk) begin
    stall_ph <= ~stall_ph;
    fvalid   <= freq && (!stall_mode || stall_ph);
    fdata    <= mem_byte(faddr);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q.size() == 0) chk(1'b0, "R11", "unexpected done", 32'(ea), 32'h0);
      else begin
        exp_t e;
        e = q.pop_front();
        chk(ea == e.ea, e.tag, "ea", 32'(ea), 32'(e.ea));
        chk(ss == e.ss, "R6", "ss_dflt", 32'(ss), 32'(e.ss));
        chk(rg == e.rg, "R1", "reg", 32'(rg), 32'(e.rg));
        chk(rm == e.rm, "R1", "rm", 32'(rm), 32'(e.rm));
        chk(rdir == e.dir, "R8", "reg_direct", 32'(rdir), 32'(e.dir));
        chk(ip_out == e.ip, "R7", "ip", 32'(ip_out), 32'(e.ip));
      end
    end
  end

  // independent model of the requirements
  function automatic exp_t model(input logic [7:0] m, input logic [15:0] vbx, vbp, vsi,
                                 vdi, vcs, vip);
    exp_t e;
    logic [1:0] md = m[7:6];
    logic [2:0] r = m[2:0];
    int nb;
    logic [15:0] d, base;
    logic [7:0] b0, b1;
    b0 = mem_byte(20'(({4'h0, vcs} << 4) + 20'(vip)));
    b1 = mem_byte(20'(({4'h0, vcs} << 4) + 20'(16'(vip + 16'd1))));
    case (r)
      0: base = vbx + vsi; 1: base = vbx + vdi; 2: base = vbp + vsi; 3: base = vbp + vdi;
      4: base = vsi; 5: base = vdi; 6: base = vbp; default: base = vbx;
    endcase
    e.rg = m[5:3]; e.rm = r; e.dir = (md == 2'b11); e.ss = 1'b0;
    if (md == 2'b11) begin nb = 0; e.ea = 16'h0; e.tag = "R8"; end
    else if (md == 2'b00 && r == 3'd6) begin nb = 2; e.ea = {b1, b0}; e.tag = "R3"; end
    else begin
      if (md == 2'b00) begin nb = 0; d = 16'h0; e.tag = "R2"; end
      else if (md == 2'b01) begin nb = 1; d = {{8{b0[7]}}, b0}; e.tag = "R4"; end
      else begin nb = 2; d = {b1, b0}; e.tag = "R5"; end
      e.ea = base + d;
      e.ss = (r == 3'd2 || r == 3'd3 || r == 3'd6);
    end
    e.ip = vip + 16'(nb);
    return e;
  endfunction

  // driver: push expectation, start, poke while busy (R11), time done (R13)
  task automatic run_op(input logic [7:0] m, input logic [15:0] vbx, vbp, vsi, vdi,
                        vcs, vip, input bit poke);
    exp_t e;
    int lat, nb;
    e = model(m, vbx, vbp, vsi, vdi, vcs, vip);
    nb = (m[7:6] == 2'b11 || (m[7:6] == 2'b00 && m[2:0] != 3'd6)) ? 0 :
         (m[7:6] == 2'b01) ? 1 : 2;
    q.push_back(e);
    @(negedge clk);
    modrm = m; bx = vbx; bp = vbp; si = vsi; di = vdi; cs = vcs; ip = vip; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    modrm = ~m; bx = ~vbx; bp = ~vbp; si = ~vsi; di = ~vdi; cs = ~vcs; ip = ~vip;
    lat = 1;
    if (poke && !done) begin
      start = 1'b1; modrm = 8'hC7;
    end
    while (!done && lat < 40) begin
      @(negedge clk); start = 1'b0; lat++;
    end
    start = 1'b0;
    if (!stall_mode) chk(lat == nb + 1, "R13", "done latency", 32'(lat), 32'(nb + 1));
    repeat (3) begin
      @(negedge clk);
      chk(!done, poke ? "R11" : "R13", "done after pulse", 32'(done), 32'h0);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R12", "watchdog", 32'h0, 32'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk(!busy, "R12", "busy", 32'(busy), 32'h0);
    chk(!done, "R12", "done", 32'(done), 32'h0);
    chk(!freq, "R12", "fetch_req", 32'(freq), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !freq, "R12", "idle after release", 32'({busy, freq}), 32'h0);

    // all modes and rm values: R2 R3 R4 R5 R8
    for (int md = 0; md < 4; md++)
      for (int r = 0; r < 8; r++)
        run_op({2'(md), 3'(r ^ 5), 3'(r)}, 16'h1234, 16'h8F00, 16'h0456, 16'h7001,
               16'h2000 + 16'(md * 16), 16'h0100 + 16'(r * 37), 1'b0);
    // sign extension with both byte polarities: R4
    for (int k = 0; k < 8; k++)
      run_op(8'b01_010_111, 16'h4000, 16'h0, 16'h0, 16'h0, 16'h0000, 16'(k * 16'h0011), 1'b0);
    // offset wrap R9
    run_op(8'b00_001_000, 16'hFFFF, 16'h0, 16'h0002, 16'h0, 16'h1000, 16'h0010, 1'b0);
    run_op(8'b10_000_011, 16'h0, 16'hFFF0, 16'h0, 16'h0020, 16'h0F00, 16'h0040, 1'b0);
    // physical address truncation and IP wrap R7
    run_op(8'b00_111_110, 16'h0, 16'h0, 16'h0, 16'h0, 16'hFFFF, 16'h0010, 1'b0);
    run_op(8'b10_101_110, 16'h0, 16'h0300, 16'h0, 16'h0, 16'h3000, 16'hFFFF, 1'b0);
    // stalled fetch R10
    stall_mode = 1'b1;
    run_op(8'b10_110_010, 16'h0, 16'h0101, 16'h0202, 16'h0, 16'h0500, 16'h0070, 1'b0);
    run_op(8'b00_000_110, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0600, 16'h0033, 1'b0);
    run_op(8'b01_011_001, 16'h0800, 16'h0, 16'h0, 16'h0010, 16'h0700, 16'h0081, 1'b0);
    stall_mode = 1'b0;
    // starts while busy are ignored R11
    run_op(8'b10_001_100, 16'h0, 16'h0, 16'h1111, 16'h0, 16'h0900, 16'h0002, 1'b1);
    run_op(8'b11_100_101, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0, 1'b1);
    run_op(8'b00_010_110, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0A00, 16'h0005, 1'b1);
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R11", "outstanding results", 32'(q.size()), 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule